// File: doc/BRIEF.md
# Bus-Takeover EEPROM Image Loader

This controller borrows a host processor's parallel memory bus in order to program a byte-wide EEPROM that sits at the bottom of the address map. A command supplies a start address and a byte count. The controller first checks that the whole span lies inside the 16 KiB ROM window. It then asks the processor for the bus with an active-low request line and waits for the active-low grant. Once it holds the bus, it pulls one byte at a time from a valid/ready byte source and reads the current contents of the target location. It writes only when the stored byte differs from the new one. After each write it waits out the device's write cycle before it issues any further memory strobe. Reading is fast and writing is slow, so the skip makes a repeated load of an unchanged image cheap.

The controller is a single state machine with the states ST_IDLE, ST_REQ, ST_FETCH, ST_RD_SETUP, ST_RD_STROBE, ST_RD_CAP, ST_COMPARE, ST_WR_SETUP, ST_WR_STROBE, ST_WR_HOLD, ST_WAIT, ST_NEXT and ST_RELEASE.

The transitions are:
- ST_IDLE moves to ST_REQ on an accepted command. A rejected command leaves it in ST_IDLE.
- ST_REQ moves to ST_FETCH once the grant is seen.
- ST_FETCH moves to ST_RD_SETUP when a source byte is taken.
- The read path runs ST_RD_SETUP, then ST_RD_STROBE, then ST_RD_CAP, then ST_COMPARE.
- ST_COMPARE moves to ST_NEXT when the bytes match and to ST_WR_SETUP when they differ.
- The write path runs ST_WR_SETUP, then ST_WR_STROBE, then ST_WR_HOLD, then ST_WAIT.
- ST_WAIT moves to ST_NEXT when the recovery timer expires.
- ST_NEXT moves to ST_FETCH while bytes remain, and to ST_RELEASE after the last one.
- ST_RELEASE returns to ST_IDLE and raises done.

Top module: `eeprom_loader`

## Requirements
- R1: A command is rejected when its length is zero or when start plus length exceeds ROM_BYTES (0x4000). Addresses 0x4000 and above belong to RAM and are never a legal target. On a rejected command, err_range goes high and stays high until the next command, done stays low, and bus_req_n never goes low.
- R2: An accepted command drives bus_req_n low. No output enable (addr_oe, data_oe, ctl_oe) is asserted unless bus_req_n and bus_ack_n are both low.
- R3: Before any write to an address, the controller reads that same address with mreq_n and rd_n both low and wr_n high.
- R4: When the stored byte equals the new byte, no write strobe is issued and skip_count increments by one.
- R5: When the bytes differ, exactly one write strobe is issued, with mreq_n and wr_n low, rd_n high and data_oe high. The strobe carries the new byte, and wr_count increments by one.
- R6: After a write strobe, mreq_n stays high for more than WRITE_WAIT_CYCLES cycles.
- R7: The target addresses run upward by one from cmd_start. Each address consumes exactly one source byte, taken on a cycle where src_valid and src_ready are both high. The source may stall at any time.
- R8: After the last byte, the controller drops every output enable and then raises bus_req_n. done rises and stays high with the bus released until the next command.
- R9: When done is high, wr_count plus skip_count equals the accepted cmd_len.
- R10: rd_n and wr_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled only while idle |
| cmd_start | input | ADDR_W | First target address |
| cmd_len | input | ADDR_W | Number of bytes to load |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Controller takes the source byte this cycle |
| bus_req_n | output | 1 | Active-low bus request to the processor |
| bus_ack_n | input | 1 | Active-low bus grant from the processor |
| addr_o | output | ADDR_W | Address driven onto the bus |
| addr_oe | output | 1 | Address driver enable |
| data_o | output | 8 | Write data driven onto the bus |
| data_i | input | 8 | Data read back from the bus |
| data_oe | output | 1 | Data driver enable |
| ctl_oe | output | 1 | Strobe driver enable |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | Job finished and bus released |
| err_range | output | 1 | Last command was rejected |
| wr_count | output | ADDR_W | Bytes written in the last job |
| skip_count | output | ADDR_W | Bytes skipped in the last job |

## Verification
The bus-ownership assertion assumes that the processor, once it has granted the bus, keeps bus_ack_n low for as long as bus_req_n stays low, and releases the grant only after the request is withdrawn. The bench's processor model grants the bus three cycles after the request falls and drops the grant as soon as the request rises, so it never revokes a grant mid-job. The read and write checks assume that data_i reflects the addressed byte while the read strobes are low. The bench memory model returns the stored byte combinationally under exactly those strobes, and the source model stalls on a fixed rhythm without ever changing a byte it has offered.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_FETCH,
        ST_RD_SETUP,
        ST_RD_STROBE,
        ST_RD_CAP,
        ST_COMPARE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_WAIT,
        ST_NEXT,
        ST_RELEASE
    } ldr_state_t;

    typedef struct packed {
        logic req_n;
        logic addr_oe;
        logic data_oe;
        logic ctl_oe;
        logic mreq_n;
        logic rd_n;
        logic wr_n;
        logic src_ready;
    } bus_ctl_t;

endpackage

// File: rtl/eeld_range_check.sv
module eeld_range_check #(
    parameter int ADDR_W    = 16,
    parameter int ROM_BYTES = 16384
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [ADDR_W-1:0] len,
    output logic              ok
);
    localparam int SUM_W = ADDR_W + 2;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(ROM_BYTES);

    logic [SUM_W-1:0] span_end;

    always_comb begin
        span_end = {2'b00, start} + {2'b00, len};
        ok       = (len != '0) && (span_end <= LIMIT);
    end
endmodule

// File: rtl/eeld_wait_timer.sv
module eeld_wait_timer #(
    parameter int WAIT_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expired
);
    localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/eeld_tally.sv
module eeld_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_wr,
    input  logic             inc_skip,
    output logic [CNT_W-1:0] wr_count,
    output logic [CNT_W-1:0] skip_count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_count   <= '0;
            skip_count <= '0;
        end else if (clr) begin
            wr_count   <= '0;
            skip_count <= '0;
        end else begin
            if (inc_wr)   wr_count   <= wr_count + 1'b1;
            if (inc_skip) skip_count <= skip_count + 1'b1;
        end
    end
endmodule

// File: rtl/eeld_bus_drive.sv
module eeld_bus_drive
    import eeld_pkg::*;
(
    input  ldr_state_t state,
    output bus_ctl_t   ctl
);
    // Output decode: one Moore output set per state.
    always_comb begin
        ctl = '{req_n: 1'b1, addr_oe: 1'b0, data_oe: 1'b0, ctl_oe: 1'b0,
                mreq_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, src_ready: 1'b0};
        unique case (state)
            ST_IDLE: ;
            ST_REQ, ST_RELEASE: begin
                ctl.req_n = 1'b0;
            end
            ST_FETCH: begin
                ctl.req_n     = 1'b0;
                ctl.addr_oe   = 1'b1;
                ctl.ctl_oe    = 1'b1;
                ctl.src_ready = 1'b1;
            end
            ST_RD_SETUP, ST_COMPARE, ST_WAIT, ST_NEXT: begin
                ctl.req_n   = 1'b0;
                ctl.addr_oe = 1'b1;
                ctl.ctl_oe  = 1'b1;
            end
            ST_RD_STROBE, ST_RD_CAP: begin
                ctl.req_n   = 1'b0;
                ctl.addr_oe = 1'b1;
                ctl.ctl_oe  = 1'b1;
                ctl.mreq_n  = 1'b0;
                ctl.rd_n    = 1'b0;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                ctl.req_n   = 1'b0;
                ctl.addr_oe = 1'b1;
                ctl.ctl_oe  = 1'b1;
                ctl.data_oe = 1'b1;
            end
            ST_WR_STROBE: begin
                ctl.req_n   = 1'b0;
                ctl.addr_oe = 1'b1;
                ctl.ctl_oe  = 1'b1;
                ctl.data_oe = 1'b1;
                ctl.mreq_n  = 1'b0;
                ctl.wr_n    = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader
    import eeld_pkg::*;
#(
    parameter int ADDR_W            = 16,
    parameter int ROM_BYTES         = 16384,
    parameter int WRITE_WAIT_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_start,
    input  logic [ADDR_W-1:0] cmd_len,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              src_ready,
    output logic              bus_req_n,
    input  logic              bus_ack_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe,
    output logic [7:0]        data_o,
    input  logic [7:0]        data_i,
    output logic              data_oe,
    output logic              ctl_oe,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              done,
    output logic              err_range,
    output logic [ADDR_W-1:0] wr_count,
    output logic [ADDR_W-1:0] skip_count
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    ldr_state_t        state, state_nx;
    bus_ctl_t          ctl;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] remain;
    logic [7:0]        new_byte;
    logic [7:0]        old_byte;
    logic              done_r;
    logic              err_r;
    logic              range_ok;
    logic              wait_over;
    logic              take_cmd;
    logic              bytes_match;

    eeld_range_check #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) u_range (
        .start (cmd_start),
        .len   (cmd_len),
        .ok    (range_ok)
    );

    eeld_wait_timer #(.WAIT_CYCLES(WRITE_WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state == ST_WR_HOLD),
        .tick    (state == ST_WAIT),
        .expired (wait_over)
    );

    eeld_tally #(.CNT_W(ADDR_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (take_cmd && range_ok),
        .inc_wr     (state == ST_WR_HOLD),
        .inc_skip   (state == ST_COMPARE && bytes_match),
        .wr_count   (wr_count),
        .skip_count (skip_count)
    );

    eeld_bus_drive u_drive (
        .state (state),
        .ctl   (ctl)
    );

    assign take_cmd    = (state == ST_IDLE) && cmd_valid;
    assign bytes_match = (old_byte == new_byte);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (cmd_valid && range_ok) state_nx = ST_REQ;
            ST_REQ:       if (!bus_ack_n) state_nx = ST_FETCH;
            ST_FETCH:     if (src_valid) state_nx = ST_RD_SETUP;
            ST_RD_SETUP:  state_nx = ST_RD_STROBE;
            ST_RD_STROBE: state_nx = ST_RD_CAP;
            ST_RD_CAP:    state_nx = ST_COMPARE;
            ST_COMPARE:   state_nx = bytes_match ? ST_NEXT : ST_WR_SETUP;
            ST_WR_SETUP:  state_nx = ST_WR_STROBE;
            ST_WR_STROBE: state_nx = ST_WR_HOLD;
            ST_WR_HOLD:   state_nx = ST_WAIT;
            ST_WAIT:      if (wait_over) state_nx = ST_NEXT;
            ST_NEXT:      state_nx = (remain == ONE) ? ST_RELEASE : ST_FETCH;
            ST_RELEASE:   state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Job datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
            new_byte <= '0;
            old_byte <= '0;
            done_r   <= 1'b0;
            err_r    <= 1'b0;
        end else begin
            if (take_cmd) begin
                done_r <= 1'b0;
                err_r  <= !range_ok;
                if (range_ok) begin
                    cur_addr <= cmd_start;
                    remain   <= cmd_len;
                end
            end
            if (state == ST_FETCH && src_valid) new_byte <= src_data;
            if (state == ST_RD_CAP)             old_byte <= data_i;
            if (state == ST_NEXT && remain != ONE) begin
                cur_addr <= cur_addr + ONE;
                remain   <= remain - ONE;
            end
            if (state == ST_RELEASE) done_r <= 1'b1;
        end
    end

    assign bus_req_n = ctl.req_n;
    assign addr_oe   = ctl.addr_oe;
    assign data_oe   = ctl.data_oe;
    assign ctl_oe    = ctl.ctl_oe;
    assign mreq_n    = ctl.mreq_n;
    assign rd_n      = ctl.rd_n;
    assign wr_n      = ctl.wr_n;
    assign src_ready = ctl.src_ready;
    assign addr_o    = cur_addr;
    assign data_o    = new_byte;
    assign done      = done_r;
    assign err_range = err_r;
endmodule

// File: rtl/eeprom_loader_chk.sv
module eeprom_loader_chk #(
    parameter int ADDR_W = 16,
    parameter int WAIT   = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_n,
    input logic              bus_ack_n,
    input logic              addr_oe,
    input logic              data_oe,
    input logic              ctl_oe,
    input logic              mreq_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr_o,
    input logic              done,
    input logic              err_range
);
    localparam int GW = $clog2(WAIT + 3) + 1;
    localparam logic [GW-1:0] LIM = GW'(WAIT);

    logic [GW-1:0]     gap;
    logic              armed;
    logic              rd_seen;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_strobe;
    logic              rd_strobe;

    assign wr_strobe = ctl_oe && !mreq_n && !wr_n;
    assign rd_strobe = ctl_oe && !mreq_n && !rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap     <= '0;
            armed   <= 1'b0;
            rd_seen <= 1'b0;
            rd_addr <= '0;
        end else begin
            if (wr_strobe) begin
                gap     <= GW'(1);
                armed   <= 1'b1;
                rd_seen <= 1'b0;
            end else if (gap <= LIM) begin
                gap <= gap + 1'b1;
            end
            if (rd_strobe) begin
                rd_seen <= 1'b1;
                rd_addr <= addr_o;
            end
        end
    end

    assert_no_drive_without_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe || data_oe || ctl_oe) |-> (!bus_req_n && !bus_ack_n));

    assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_read_before_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (rd_seen && addr_o == rd_addr));

    assert_write_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !mreq_n && wr_n) |-> (gap > LIM));

    assert_data_only_for_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> rd_n);

    assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_req_n && !addr_oe && !data_oe && !ctl_oe));

    assert_error_keeps_off_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> (bus_req_n && !done));
endmodule

bind eeprom_loader eeprom_loader_chk #(.ADDR_W(ADDR_W), .WAIT(WRITE_WAIT_CYCLES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req_n (bus_req_n),
    .bus_ack_n (bus_ack_n),
    .addr_oe   (addr_oe),
    .data_oe   (data_oe),
    .ctl_oe    (ctl_oe),
    .mreq_n    (mreq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr_o    (addr_o),
    .done      (done),
    .err_range (err_range)
);

// File: tb/test_eeprom_loader.sv
`timescale 1ns/1ps
module test_eeprom_loader;
    localparam int AW = 16;
    localparam int WAITC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [AW-1:0] cmd_start = '0, cmd_len = '0;
    logic src_valid = 1'b0;
    logic [7:0] src_data;
    logic src_ready, bus_req_n, addr_oe, data_oe, ctl_oe, mreq_n, rd_n, wr_n;
    logic bus_ack_n = 1'b1;
    logic [AW-1:0] addr_o, wr_count, skip_count;
    logic [7:0] data_o, data_i;
    logic done, err_range;

    always #5 clk = ~clk;

    eeprom_loader #(.ADDR_W(AW), .ROM_BYTES(16384), .WRITE_WAIT_CYCLES(WAITC)) i_eeprom_loader (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
        .cmd_len(cmd_len), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .bus_req_n(bus_req_n), .bus_ack_n(bus_ack_n),
        .addr_o(addr_o), .addr_oe(addr_oe), .data_o(data_o), .data_i(data_i),
        .data_oe(data_oe), .ctl_oe(ctl_oe), .mreq_n(mreq_n), .rd_n(rd_n),
        .wr_n(wr_n), .done(done), .err_range(err_range),
        .wr_count(wr_count), .skip_count(skip_count));

    int checks = 0, fails = 0;
    int cyc = 0;
    bit wd_fired = 0;

    // Bench memory covering the two tested windows.
    logic [7:0] mem [0:511];
    function automatic int mix(input logic [AW-1:0] a);
        return {a[13], a[7:0]};
    endfunction

    int mode = 0;
    int src_idx = 0;
    function automatic logic [7:0] pat(input int m, input int i);
        case (m)
            0: return 8'(i);
            1: return 8'(i) ^ 8'h5A;
            default: return 8'h77;
        endcase
    endfunction
    assign src_data = pat(mode, src_idx);
    assign data_i = (ctl_oe && !mreq_n && !rd_n) ? mem[mix(addr_o)] : 8'h00;

    // Monitors
    int wr_strobes = 0, req_low_cycles = 0;
    int own_viol = 0, gap_viol = 0, rbw_viol = 0, order_viol = 0, excl_viol = 0;
    int last_wr_cyc = -100000;
    logic prev_rd = 1'b0;
    logic [AW-1:0] exp_rd_addr = '0;
    logic [AW-1:0] last_rd_addr = '0;
    bit rd_flag = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if ((addr_oe || data_oe || ctl_oe) && (bus_req_n || bus_ack_n)) own_viol++;
            if (!rd_n && !wr_n) excl_viol++;
            if (!bus_req_n) req_low_cycles++;
            if (ctl_oe && !mreq_n && !wr_n) begin
                mem[mix(addr_o)] <= data_o;
                wr_strobes++;
                if (!rd_flag || last_rd_addr != addr_o || !rd_n) rbw_viol++;
                rd_flag = 0;
                last_wr_cyc = cyc;
            end else if (ctl_oe && !mreq_n) begin
                if (cyc - last_wr_cyc <= WAITC) gap_viol++;
            end
            if (ctl_oe && !mreq_n && !rd_n) begin
                rd_flag = 1;
                last_rd_addr = addr_o;
                if (!prev_rd) begin
                    if (addr_o != exp_rd_addr) order_viol++;
                    exp_rd_addr = exp_rd_addr + 1'b1;
                end
            end
            prev_rd = ctl_oe && !mreq_n && !rd_n;
            if (src_valid && src_ready) src_idx <= src_idx + 1;
        end
    end

    // Processor bus-grant model and stalling byte source.
    int ack_dly = 0;
    always @(negedge clk) begin
        if (!bus_req_n) begin
            if (ack_dly >= 3) bus_ack_n <= 1'b0;
            else ack_dly++;
        end else begin
            ack_dly = 0;
            bus_ack_n <= 1'b1;
        end
        src_valid <= (cyc % 3) != 0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_job(input int start, input int len, input int m);
        @(negedge clk);
        mode = m;
        src_idx = 0;
        wr_strobes = 0;
        req_low_cycles = 0;
        exp_rd_addr = AW'(start);
        cmd_start = AW'(start);
        cmd_len = AW'(len);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!(done || err_range)) begin
            if (cyc > 190000) begin
                wd_fired = 1;
                return;
            end
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        check(bus_req_n === 1'b1 && !addr_oe && !ctl_oe && !data_oe, "R2 reset idle", bus_req_n, 1);
        check(done === 1'b0 && err_range === 1'b0, "R8 reset done/err", done, 0);
        rst_n = 1'b1;

        // Pass 1: fresh (all 0xFF) window, low address byte as data
        run_job(0, 256, 0);
        check(wr_count == 255, "R5 pass1 wr_count", wr_count, 255);
        check(skip_count == 1, "R4 pass1 skip_count", skip_count, 1);
        check(wr_count + skip_count == 256, "R9 pass1 sum", wr_count + skip_count, 256);
        check(wr_strobes == 255, "R5 pass1 write strobes", wr_strobes, 255);
        begin
            int bad = 0;
            for (int i = 0; i < 256; i++) if (mem[mix(AW'(i))] != 8'(i)) bad++;
            check(bad == 0, "R7 pass1 contents", bad, 0);
        end
        check(done && bus_req_n && !addr_oe && !ctl_oe && !data_oe, "R8 pass1 released", done, 1);

        // Pass 2: identical image, every write skipped
        run_job(0, 256, 0);
        check(wr_count == 0, "R4 pass2 wr_count", wr_count, 0);
        check(skip_count == 256, "R4 pass2 skip_count", skip_count, 256);
        check(wr_strobes == 0, "R4 pass2 no write strobes", wr_strobes, 0);

        // Pass 3: top window, half already matching
        for (int i = 0; i < 256; i++)
            mem[mix(AW'(16'h3F00 + i))] = (i % 2 == 0) ? pat(1, i) : ~pat(1, i);
        run_job(16'h3F00, 256, 1);
        check(wr_count == 128, "R5 pass3 wr_count", wr_count, 128);
        check(skip_count == 128, "R4 pass3 skip_count", skip_count, 128);
        check(wr_count + skip_count == 256, "R9 pass3 sum", wr_count + skip_count, 256);
        begin
            int bad = 0;
            for (int i = 0; i < 256; i++) if (mem[mix(AW'(16'h3F00 + i))] != pat(1, i)) bad++;
            check(bad == 0, "R7 pass3 contents", bad, 0);
        end

        // Boundary: last ROM byte accepted
        run_job(16'h3FFF, 1, 2);
        check(!err_range && done, "R1 last byte accepted", err_range, 0);
        check(mem[mix(16'h3FFF)] == 8'h77, "R5 last byte written", mem[mix(16'h3FFF)], 8'h77);

        // Rejections
        run_job(16'h3FFF, 2, 2);
        check(err_range && !done, "R1 span over top rejected", err_range, 1);
        check(req_low_cycles == 0, "R1 no request on reject", req_low_cycles, 0);
        run_job(0, 0, 2);
        check(err_range && req_low_cycles == 0, "R1 zero length rejected", err_range, 1);
        run_job(16'h4000, 1, 2);
        check(err_range && req_low_cycles == 0, "R1 RAM start rejected", err_range, 1);

        // Accepted job after a rejection clears the flag
        run_job(16'h0010, 4, 0);
        check(!err_range && done && skip_count == 0 && wr_count == 4, "R1 error cleared", err_range, 0);

        check(own_viol == 0, "R2 bus driven only with grant", own_viol, 0);
        check(rbw_viol == 0, "R3 read before write", rbw_viol, 0);
        check(gap_viol == 0, "R6 write recovery", gap_viol, 0);
        check(order_viol == 0, "R7 address order", order_viol, 0);
        check(excl_viol == 0, "R10 strobe exclusion", excl_viol, 0);

        if (wd_fired) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule